// File: doc/BRIEF.md
# Dual-Channel Event Counter

This block holds two independent event counters behind a small word-addressed register port. Each channel picks one of up to 64 event lines with a 6-bit code. While its enable and start bits are both set, the channel adds one to its count on every clock in which the selected line is high. Software controls a channel by writing its 16-bit control word. A first write with the clear bit set zeroes the count. A second write then loads the event code with enable and start.

The count is wider than the data bus. The low word is read at one address and the upper part at another. A read of the low word copies the upper part of the count into a per-channel shadow register, and the high-word address returns that shadow. A low-then-high read pair therefore returns one coherent value while the counter keeps running. The widths of the count and of the low word are parameters (48 and 32 by default).

Top module: `dual_event_counter`

## Requirements
- R1: After reset every control word, every low word and every high word reads as zero, so both channels start disabled.
- R2: A control write stores the event code in bits [5:0], a clock-select flag in bit 8, start in bit 14 and enable in bit 15, and these read back as written. Bit 13 (clear) reads as 0 and bit 12 reads the overflow flag. Written values of bit 12 and of the other unused bits are ignored and read as 0.
- R3: A control write with bit 13 set makes the count and the overflow flag zero on the next clock, and this wins over an increment in the same cycle.
- R4: The count of a channel grows by exactly one on each clock in which enable, start and the selected event line (event_i[code]) are all high.
- R5: The count does not change while enable or start is low, or while the code is unassigned. The unassigned codes are 0x00, 0x0C, 0x1B to 0x20, 0x26 and 0x2A to 0x3F, and they never count even when their line is high.
- R6: Code 0x23 counts every clock while the channel is enabled and started, whatever the level of event_i[35].
- R7: A count at all ones wraps to zero on its next increment and sets the overflow flag (control bit 12). The flag then stays set until a clear.
- R8: Control words sit at byte address 0x00 + 4*n. The high word of channel n is at 0x20 + 8*n and its low word at 0x24 + 8*n. A low read returns count[LO_W-1:0] zero-extended. An idle bus or an unmapped address reads zero, and writes to counter addresses have no effect.
- R9: A low-word read latches count[CNT_W-1:LO_W] into the channel's shadow register. High-word reads return that shadow even when the count has moved since.
- R10: A write to one channel's control word leaves the configuration and the count of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Register access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (6) | Byte address, word aligned |
| bus_wdata_i | input | DATA_W (32) | Write data; control uses bits [15:0] |
| bus_rdata_o | output | DATA_W (32) | Read data, combinational from the address |
| event_i | input | NUM_EVT (64) | Event lines, indexed by event code |

## Verification
The hardest state to reach is the overflow wrap of a wide count, which would need 2^48 counted clocks. The bench therefore drives a second instance that shares the same bus and event lines but has a 10-bit count split as 4 low bits and 6 high bits. It holds that instance on the cycle code for more than 1024 clocks, then checks the sticky flag and its removal by clear. The narrow low word wraps every 16 counts, so a high read made several clocks after its low read shows whether the shadow kept its value or took a later one.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int CODE_W  = 6;
  localparam int CTRL_W  = 16;
  localparam int EN_BIT  = 15;
  localparam int ST_BIT  = 14;
  localparam int CLR_BIT = 13;
  localparam int OVF_BIT = 12;
  localparam int CKS_BIT = 8;
  localparam logic [CODE_W-1:0] CYCLE_CODE = 6'h23;

  typedef struct packed {
    logic              en;
    logic              st;
    logic              cks;
    logic [CODE_W-1:0] code;
  } cfg_t;

  // codes wired to an event source
  function automatic logic code_assigned(input logic [CODE_W-1:0] c);
    return (c >= 6'h01 && c <= 6'h0b) || (c >= 6'h0d && c <= 6'h1a) ||
           (c >= 6'h21 && c <= 6'h25) || (c >= 6'h27 && c <= 6'h29);
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(input cfg_t cfg, input logic ovf);
    logic [CTRL_W-1:0] w;
    w              = '0;
    w[EN_BIT]      = cfg.en;
    w[ST_BIT]      = cfg.st;
    w[OVF_BIT]     = ovf;
    w[CKS_BIT]     = cfg.cks;
    w[CODE_W-1:0]  = cfg.code;
    return w;
  endfunction
endpackage

// File: rtl/evtcnt_regif.sv
module evtcnt_regif #(
  parameter int NUM_CH    = 2,
  parameter int ADDR_W    = 6,
  parameter int CTRL_BASE = 0,
  parameter int CNT_BASE  = 32
) (
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [NUM_CH-1:0] ctrl_wr_o,
  output logic [NUM_CH-1:0] ctrl_rd_o,
  output logic [NUM_CH-1:0] hi_rd_o,
  output logic [NUM_CH-1:0] lo_rd_o
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] wa;
  logic            rd, wr;
  logic            unused_lsb;

  assign wa         = bus_addr_i[ADDR_W-1:2];
  assign rd         = bus_en_i & ~bus_we_i;
  assign wr         = bus_en_i & bus_we_i;
  assign unused_lsb = ^bus_addr_i[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    localparam logic [WA_W-1:0] CTRL_WA = WA_W'((CTRL_BASE + 4 * g) / 4);
    localparam logic [WA_W-1:0] HI_WA   = WA_W'((CNT_BASE + 8 * g) / 4);
    localparam logic [WA_W-1:0] LO_WA   = WA_W'((CNT_BASE + 8 * g + 4) / 4);
    assign ctrl_wr_o[g] = wr && (wa == CTRL_WA);
    assign ctrl_rd_o[g] = rd && (wa == CTRL_WA);
    assign hi_rd_o[g]   = rd && (wa == HI_WA);
    assign lo_rd_o[g]   = rd && (wa == LO_WA);
  end
endmodule

// File: rtl/evtcnt_evsel.sv
module evtcnt_evsel
  import evtcnt_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic [NUM_EVT-1:0] event_i,
  output logic               hit_o
);
  localparam int PAD_W = 1 << CODE_W;

  logic [PAD_W-1:0] ev_pad;

  always_comb begin
    ev_pad              = '0;
    ev_pad[NUM_EVT-1:0] = event_i;
  end

  always_comb begin
    if (!code_assigned(code_i))   hit_o = 1'b0;
    else if (code_i == CYCLE_CODE) hit_o = 1'b1;
    else                           hit_o = ev_pad[code_i];
  end
endmodule

// File: rtl/evtcnt_channel.sv
module evtcnt_channel
  import evtcnt_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int LO_W    = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              lo_rd_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [NUM_EVT-1:0] event_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  localparam int HI_W = CNT_W - LO_W;

  cfg_t             cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [HI_W-1:0]  shd_q;
  logic             hit, active, clr;
  logic             unused_wbits;

  assign unused_wbits = ^{ctrl_wdata_i[OVF_BIT:CKS_BIT+1], ctrl_wdata_i[CKS_BIT-1:CODE_W]};

  evtcnt_evsel #(.NUM_EVT(NUM_EVT)) u_sel (
    .code_i (cfg_q.code),
    .event_i(event_i),
    .hit_o  (hit)
  );

  assign active = cfg_q.en & cfg_q.st & hit;
  assign clr    = ctrl_wr_i & ctrl_wdata_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (ctrl_wr_i) begin
      cfg_q.en   <= ctrl_wdata_i[EN_BIT];
      cfg_q.st   <= ctrl_wdata_i[ST_BIT];
      cfg_q.cks  <= ctrl_wdata_i[CKS_BIT];
      cfg_q.code <= ctrl_wdata_i[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (active) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (&cnt_q) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shd_q <= '0;
    else if (lo_rd_i) shd_q <= cnt_q[CNT_W-1:LO_W];
  end

  assign ctrl_o = pack_ctrl(cfg_q, ovf_q);
  assign lo_o   = DATA_W'(cnt_q[LO_W-1:0]);
  assign hi_o   = DATA_W'(shd_q);

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt_q == '0) && !ovf_q);
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !clr |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_q.en && cfg_q.st) && !clr |=> $stable(cnt_q));
  p_unassigned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_assigned(cfg_q.code) && !clr |=> $stable(cnt_q));
  p_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.en && cfg_q.st && (cfg_q.code == CYCLE_CODE) && !clr |=> cnt_q != $past(cnt_q));
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !clr && (&cnt_q) |=> (cnt_q == '0) && ovf_q);
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !clr |=> ovf_q);
  p_shadow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rd_i |=> shd_q == $past(cnt_q[CNT_W-1:LO_W]));
  p_shadow_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_rd_i |=> $stable(shd_q));
endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
  import evtcnt_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int NUM_EVT   = 64,
  parameter int CNT_W     = 48,
  parameter int LO_W      = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int CTRL_BASE = 0,
  parameter int CNT_BASE  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NUM_EVT-1:0] event_i
);
  localparam logic [CTRL_W-1:0] CFG_MASK = ~(CTRL_W'(1) << OVF_BIT);

  logic [NUM_CH-1:0] ctrl_wr, ctrl_rd, hi_rd, lo_rd;
  logic [CTRL_W-1:0] ctrl_q [NUM_CH];
  logic [DATA_W-1:0] lo_q   [NUM_CH];
  logic [DATA_W-1:0] hi_q   [NUM_CH];
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CTRL_W];

  evtcnt_regif #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .CTRL_BASE(CTRL_BASE),
    .CNT_BASE (CNT_BASE)
  ) u_regif (
    .bus_en_i  (bus_en_i),
    .bus_we_i  (bus_we_i),
    .bus_addr_i(bus_addr_i),
    .ctrl_wr_o (ctrl_wr),
    .ctrl_rd_o (ctrl_rd),
    .hi_rd_o   (hi_rd),
    .lo_rd_o   (lo_rd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evtcnt_channel #(
      .CNT_W  (CNT_W),
      .LO_W   (LO_W),
      .DATA_W (DATA_W),
      .NUM_EVT(NUM_EVT)
    ) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctrl_wr_i   (ctrl_wr[c]),
      .lo_rd_i     (lo_rd[c]),
      .ctrl_wdata_i(bus_wdata_i[CTRL_W-1:0]),
      .event_i     (event_i),
      .ctrl_o      (ctrl_q[c]),
      .lo_o        (lo_q[c]),
      .hi_o        (hi_q[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ctrl_rd[c]) bus_rdata_o = bus_rdata_o | DATA_W'(ctrl_q[c]);
      if (hi_rd[c])   bus_rdata_o = bus_rdata_o | hi_q[c];
      if (lo_rd[c])   bus_rdata_o = bus_rdata_o | lo_q[c];
    end
  end

  p_idle_rdata_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_i |-> bus_rdata_o == '0);

  if (NUM_CH > 1) begin : g_indep
    p_indep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr[0] |=> $stable(ctrl_q[1] & CFG_MASK));
  end
endmodule

// File: tb/dual_event_counter_test.sv
module dual_event_counter_test;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [63:0] ev = '0;
  logic [31:0] rd_big, rd_small;
  int          ev_mode = 0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  dual_event_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rd_big), .event_i(ev));

  dual_event_counter #(.CNT_W(10), .LO_W(4)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rd_small), .event_i(ev));

  // reference model: [instance][channel]
  longint unsigned m_cnt [2][2];
  longint unsigned m_shd [2][2];
  logic [15:0]     m_cfg [2][2];
  bit              m_ovf [2][2];

  function automatic int cw(int i); return (i == 0) ? 48 : 10; endfunction
  function automatic int lw(int i); return (i == 0) ? 32 : 4;  endfunction

  function automatic bit code_live(int c);
    if (c == 0 || c == 12 || c == 38 || c > 41) return 0;
    if (c >= 27 && c <= 32) return 0;
    return 1;
  endfunction

  function automatic bit ch_hit(int i, int ch);
    logic [15:0] f;
    int c;
    f = m_cfg[i][ch];
    c = int'(f[5:0]);
    if (!(f[15] && f[14] && code_live(c))) return 0;
    if (c == 35) return 1;
    return ev[c];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++)
        for (int ch = 0; ch < 2; ch++) begin
          m_cnt[i][ch] = 0; m_shd[i][ch] = 0; m_cfg[i][ch] = 0; m_ovf[i][ch] = 0;
        end
    end else begin
      for (int i = 0; i < 2; i++)
        for (int ch = 0; ch < 2; ch++) begin
          bit h;
          longint unsigned mx;
          h  = ch_hit(i, ch);
          mx = (64'd1 << cw(i)) - 1;
          if (bus_en && !bus_we && int'(bus_addr) == 36 + 8 * ch)
            m_shd[i][ch] = m_cnt[i][ch] >> lw(i);
          if (bus_en && bus_we && int'(bus_addr) == 4 * ch && bus_wdata[13]) begin
            m_cnt[i][ch] = 0; m_ovf[i][ch] = 0;
          end else if (h) begin
            if (m_cnt[i][ch] == mx) begin m_cnt[i][ch] = 0; m_ovf[i][ch] = 1; end
            else m_cnt[i][ch] = m_cnt[i][ch] + 1;
          end
          if (bus_en && bus_we && int'(bus_addr) == 4 * ch)
            m_cfg[i][ch] = bus_wdata[15:0] & 16'hC13F;
        end
    end
  end

  function automatic logic [31:0] expect_rd(int i, int a);
    for (int ch = 0; ch < 2; ch++) begin
      if (a == 4 * ch)      return {16'h0, m_cfg[i][ch] | (m_ovf[i][ch] ? 16'h1000 : 16'h0)};
      if (a == 32 + 8 * ch) return 32'(m_shd[i][ch]);
      if (a == 36 + 8 * ch) return 32'(m_cnt[i][ch] & ((64'd1 << lw(i)) - 1));
    end
    return 32'h0;
  endfunction

  task automatic drive_ev();
    case (ev_mode)
      1:       ev = '1;
      2:       ev = '0;
      default: ev = {$urandom, $urandom};
    endcase
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      bus_en = 0; bus_we = 0; drive_ev();
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d; drive_ev();
  endtask

  task automatic rd(int a, string tag);
    logic [31:0] e0, e1;
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = AW'(a); drive_ev();
    #1;
    e0 = expect_rd(0, a);
    e1 = expect_rd(1, a);
    n_chk++;
    if (rd_big !== e0) begin
      n_bad++;
      $display("FAIL %s wide addr=%02h actual=%h expected=%h", tag, a, rd_big, e0);
    end
    n_chk++;
    if (rd_small !== e1) begin
      n_bad++;
      $display("FAIL %s narrow addr=%02h actual=%h expected=%h", tag, a, rd_small, e1);
    end
  endtask

  task automatic read_all(string tag);
    rd(0, tag); rd(4, tag); rd(36, tag); rd(32, tag); rd(44, tag); rd(40, tag);
  endtask

  initial begin
    int bad_codes[7] = '{0, 12, 27, 32, 38, 42, 63};
    void'($urandom(32'd1234567));
    repeat (3) @(negedge clk);
    rst_n = 1;
    read_all("R1");

    wr(0, 32'hABCD_D1EA); rd(0, "R2");
    wr(4, 32'h0000_013F); rd(4, "R2");
    wr(0, 32'h2000); wr(4, 32'h2000);

    ev_mode = 2;
    wr(0, 32'hC023); idle(20); rd(36, "R6"); rd(32, "R6");

    ev_mode = 1;
    wr(4, 32'h8011); idle(10); rd(44, "R5 enable only");
    wr(4, 32'h4011); idle(10); rd(44, "R5 start only");
    foreach (bad_codes[k]) begin
      wr(4, 32'hC000 | 32'(bad_codes[k])); idle(5); rd(44, "R5 unassigned code");
    end

    ev_mode = 0;
    wr(4, 32'hC011); idle(30); rd(44, "R4"); rd(40, "R4");
    wr(4, 32'hC001); rd(0, "R10"); rd(36, "R10");

    wr(0, 32'hE023); rd(36, "R3"); rd(0, "R3");

    ev_mode = 2;
    idle(1030); rd(0, "R7 overflow set"); rd(36, "R7");
    idle(20); rd(0, "R7 sticky");
    wr(0, 32'hE023); rd(0, "R3 clears overflow");

    rd(36, "R9"); idle(7); rd(32, "R9 coherent high");
    idle(9); rd(32, "R9 shadow held");

    wr(40, 32'hFFFF_FFFF); wr(36, 32'h1234_5678); rd(44, "R8 counter write ignored");
    rd(16, "R8 unmapped");

    ev_mode = 0;
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 2) begin
        logic [31:0] d;
        d = $urandom;
        d[15] = ($urandom % 4) != 0;
        d[14] = ($urandom % 4) != 0;
        d[13] = ($urandom % 8) == 0;
        if ($urandom % 2) d[5:0] = 6'(1 + $urandom % 41);
        wr(4 * int'($urandom % 2), d);
      end else if (r < 6) begin
        int addrs[7] = '{0, 4, 32, 36, 40, 44, 8};
        rd(addrs[$urandom % 7], "R8 R10 random");
      end else begin
        if ($urandom % 4 == 0) ev_mode = int'($urandom % 3);
        idle(1 + int'($urandom % 5));
      end
    end
    read_all("R4 R10 final");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule